// File: doc/BRIEF.md
# FIFO Status Flag Generator with Selectable Timing Mode

This block turns a FIFO occupancy level into five registered status flags. The five flags are full or input-ready, empty or output-ready, half-full, almost-empty and almost-full. The occupancy comes from elsewhere, and so do the two programmed offsets: `empty_ofs_i` (n) sets how close to empty the almost-empty flag starts, and `full_ofs_i` (m) sets how close to full the almost-full flag starts. Pointer logic and offset programming live outside this block. All inputs are sampled on one clock.

Two timing modes exist. In standard mode the capacity is `DEPTH` words, and the full and empty flags are active-low "full" and "empty" indications. In fall-through mode one extra word sits in the output stage, so the capacity is `DEPTH+1`. In that mode every threshold moves up by one word, and the two boundary flags flip meaning: the empty flag becomes an active-low "data ready" flag and the full flag becomes an active-low "space available" flag.

A full reset samples the mode from `mode_sel_i`. A partial reset keeps the mode that is already stored. Both kinds of reset put every flag into its idle state.

Top module: `fifo_flag_gen`

## Requirements
- R1: While `rst_all` is high, the mode is loaded from `mode_sel_i` (0 = standard, 1 = fall-through), and every flag takes its idle value: `half_n_o`=1, `aempty_n_o`=0, `afull_n_o`=1. The boundary flags idle at `eo_o`=0 and `fi_o`=1 in standard mode, and at `eo_o`=1 and `fi_o`=0 in fall-through mode.
- R2: `rst_part` gives the same idle values as R1 for the stored mode, and ignores `mode_sel_i`, so the mode is unchanged afterwards.
- R3: In standard mode, `eo_o` is 1 exactly when the level sampled two edges earlier was nonzero.
- R4: In standard mode, `fi_o` is 0 exactly when the level sampled two edges earlier equalled `DEPTH`.
- R5: In fall-through mode, `eo_o` is 1 exactly when the level sampled three edges earlier was zero.
- R6: In fall-through mode, `fi_o` is 1 exactly when the level sampled two edges earlier equalled `DEPTH+1`.
- R7: `aempty_n_o` is 0 one edge after a level of at most n (standard) or at most n+1 (fall-through), and 1 otherwise.
- R8: `half_n_o` is 0 one edge after a level above `DEPTH/2` (standard) or above `DEPTH/2+1` (fall-through), and 1 otherwise.
- R9: `afull_n_o` is 0 one edge after a level of at least `DEPTH-m` (standard) or at least `DEPTH+1-m` (fall-through), and 1 otherwise.
- R10: The offsets n and m are sampled on the same edge as the level they are compared with. A change to an offset takes effect with the same one-edge latency as a change to the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_all | input | 1 | Synchronous full reset, active high; loads the mode |
| rst_part | input | 1 | Synchronous partial reset, active high; keeps the mode |
| mode_sel_i | input | 1 | Mode choice sampled during full reset: 0 standard, 1 fall-through |
| level_i | input | CNT_W | Words currently held, 0 to DEPTH+1 |
| empty_ofs_i | input | OFS_W | Almost-empty offset n |
| full_ofs_i | input | OFS_W | Almost-full offset m |
| fi_o | output | 1 | Full flag (standard, 0 = full) or input-ready flag (fall-through, 0 = space available) |
| eo_o | output | 1 | Empty flag (standard, 0 = empty) or output-ready flag (fall-through, 0 = data ready) |
| half_n_o | output | 1 | Half-full, active low |
| aempty_n_o | output | 1 | Almost-empty, active low |
| afull_n_o | output | 1 | Almost-full, active low |

## Verification
The bench sweeps the level across every value in both modes and compares each flag with a reference that is delayed by that flag's own latency. A design that used the standard thresholds in fall-through mode would switch almost-empty, half-full and almost-full one word early. A design that gave the output-ready flag two stages instead of three would show the flag a cycle early whenever the level crosses zero. Random offset changes and abrupt jumps in the level test that offsets and level are sampled together. A partial reset applied with the opposite mode select test that the mode is kept; a design that reloaded it would invert both boundary flags.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FALL = 1'b1
  } mode_e;

  typedef struct packed {
    logic fi;
    logic eo;
    logic half_n;
    logic aempty_n;
    logic afull_n;
  } flags_t;

  // Flag values held during and right after any reset
  function automatic flags_t idle_flags(mode_e md);
    flags_t f;
    f.fi       = (md == MODE_STD);
    f.eo       = (md == MODE_FALL);
    f.half_n   = 1'b1;
    f.aempty_n = 1'b0;
    f.afull_n  = 1'b1;
    return f;
  endfunction

endpackage

// File: rtl/ffg_thresh.sv
module ffg_thresh
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11,
  parameter int OFS_W = 10
) (
  input  mode_e              mode_i,
  input  logic [CNT_W-1:0]   level_i,
  input  logic [OFS_W-1:0]   eofs_i,
  input  logic [OFS_W-1:0]   fofs_i,
  output flags_t             raw_o
);

  localparam int WW = CNT_W + 1;
  localparam logic [WW-1:0] CAP  = WW'(DEPTH);
  localparam logic [WW-1:0] HALF = WW'(DEPTH / 2);

  logic [WW-1:0] lvl, extra, ae_lim, hf_lim, af_lim, top_lvl;
  logic          fall;

  always_comb begin
    fall    = (mode_i == MODE_FALL);
    extra   = fall ? WW'(1) : '0;
    lvl     = WW'(level_i);
    ae_lim  = WW'(eofs_i) + extra;
    hf_lim  = HALF + extra;
    af_lim  = CAP - WW'(fofs_i) + extra;
    top_lvl = CAP + extra;

    raw_o.fi       = fall ? (lvl == top_lvl) : (lvl != top_lvl);
    raw_o.eo       = fall ? (lvl == '0)      : (lvl != '0);
    raw_o.half_n   = !(lvl > hf_lim);
    raw_o.aempty_n = !(lvl <= ae_lim);
    raw_o.afull_n  = !(lvl >= af_lim);
  end

endmodule

// File: rtl/ffg_pipe.sv
module ffg_pipe #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WIDTH-1:0]              rst_val,
  input  logic [WIDTH-1:0]              d,
  output logic [STAGES-1:0][WIDTH-1:0]  taps
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= rst_val;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_tap
    assign taps[g] = stage_q[g];
  end

endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
  import fifo_flag_pkg::*;
#(
  parameter  int DEPTH          = 1024,
  parameter  int FI_STAGES      = 2,
  parameter  int EO_STD_STAGES  = 2,
  parameter  int EO_FALL_STAGES = 3,
  localparam int CNT_W          = $clog2(DEPTH + 2),
  localparam int OFS_W          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_all,
  input  logic              rst_part,
  input  logic              mode_sel_i,
  input  logic [CNT_W-1:0]  level_i,
  input  logic [OFS_W-1:0]  empty_ofs_i,
  input  logic [OFS_W-1:0]  full_ofs_i,
  output logic              fi_o,
  output logic              eo_o,
  output logic              half_n_o,
  output logic              aempty_n_o,
  output logic              afull_n_o
);

  localparam int EO_MAX = (EO_FALL_STAGES > EO_STD_STAGES) ? EO_FALL_STAGES : EO_STD_STAGES;

  mode_e  mode_q;
  mode_e  rst_mode;
  logic   rst_any;
  flags_t raw;
  flags_t idle;

  logic [0:0][2:0]        lvl_taps;
  logic [FI_STAGES-1:0]   fi_taps;
  logic [EO_MAX-1:0]      eo_taps;

  always_ff @(posedge clk) begin
    if (rst_all) mode_q <= mode_e'(mode_sel_i);
  end

  assign rst_any  = rst_all | rst_part;
  assign rst_mode = rst_all ? mode_e'(mode_sel_i) : mode_q;
  assign idle     = idle_flags(rst_mode);

  ffg_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_thresh (
    .mode_i  (mode_q),
    .level_i (level_i),
    .eofs_i  (empty_ofs_i),
    .fofs_i  (full_ofs_i),
    .raw_o   (raw)
  );

  ffg_pipe #(.WIDTH(3), .STAGES(1)) u_lvl_pipe (
    .clk     (clk),
    .rst     (rst_any),
    .rst_val ({idle.half_n, idle.aempty_n, idle.afull_n}),
    .d       ({raw.half_n, raw.aempty_n, raw.afull_n}),
    .taps    (lvl_taps)
  );

  ffg_pipe #(.WIDTH(1), .STAGES(FI_STAGES)) u_fi_pipe (
    .clk     (clk),
    .rst     (rst_any),
    .rst_val (idle.fi),
    .d       (raw.fi),
    .taps    (fi_taps)
  );

  ffg_pipe #(.WIDTH(1), .STAGES(EO_MAX)) u_eo_pipe (
    .clk     (clk),
    .rst     (rst_any),
    .rst_val (idle.eo),
    .d       (raw.eo),
    .taps    (eo_taps)
  );

  assign half_n_o   = lvl_taps[0][2];
  assign aempty_n_o = lvl_taps[0][1];
  assign afull_n_o  = lvl_taps[0][0];
  assign fi_o       = fi_taps[FI_STAGES-1];
  assign eo_o       = (mode_q == MODE_FALL) ? eo_taps[EO_FALL_STAGES-1]
                                            : eo_taps[EO_STD_STAGES-1];

endmodule

// File: rtl/ffg_checker.sv
module ffg_checker
  import fifo_flag_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH + 2),
  localparam int OFS_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_all,
  input logic              rst_part,
  input logic              mode_sel_i,
  input mode_e             mode_q,
  input logic [CNT_W-1:0]  level_i,
  input logic [OFS_W-1:0]  empty_ofs_i,
  input logic [OFS_W-1:0]  full_ofs_i,
  input logic              fi_o,
  input logic              eo_o,
  input logic              half_n_o,
  input logic              aempty_n_o,
  input logic              afull_n_o
);

  logic rst_any;
  logic fall;
  int   k;
  logic ae_hit, hf_hit, af_hit, fi_ref, eo_ref;

  always_comb begin
    rst_any = rst_all | rst_part;
    fall    = (mode_q == MODE_FALL);
    k       = fall ? 1 : 0;
    ae_hit  = int'(level_i) <= int'(empty_ofs_i) + k;
    hf_hit  = int'(level_i) >  DEPTH / 2 + k;
    af_hit  = int'(level_i) >= DEPTH - int'(full_ofs_i) + k;
    fi_ref  = fall ? (int'(level_i) == DEPTH + 1) : (int'(level_i) != DEPTH);
    eo_ref  = fall ? (level_i == '0) : (level_i != '0);
  end

  // R1
  full_reset_idle_chk: assert property (@(posedge clk)
    rst_all |=> (mode_q == mode_e'($past(mode_sel_i))) && half_n_o && !aempty_n_o && afull_n_o
                && (fi_o == (mode_q == MODE_STD)) && (eo_o == (mode_q == MODE_FALL)));

  // R2
  part_reset_keep_chk: assert property (@(posedge clk)
    (rst_part && !rst_all) |=> $stable(mode_q) && half_n_o && !aempty_n_o && afull_n_o);

  // R3
  std_empty_chk: assert property (@(posedge clk) disable iff (rst_any)
    (!fall ##1 !fall) |=> (eo_o == $past(eo_ref, 2)));

  // R4
  std_full_chk: assert property (@(posedge clk) disable iff (rst_any)
    (!fall ##1 !fall) |=> (fi_o == $past(fi_ref, 2)));

  // R5
  fall_ready_chk: assert property (@(posedge clk) disable iff (rst_any)
    (fall ##1 fall ##1 fall) |=> (eo_o == $past(eo_ref, 3)));

  // R6
  fall_space_chk: assert property (@(posedge clk) disable iff (rst_any)
    (fall ##1 fall) |=> (fi_o == $past(fi_ref, 2)));

  // R7
  aempty_level_chk: assert property (@(posedge clk) disable iff (rst_any)
    1'b1 |=> (aempty_n_o == !$past(ae_hit)));

  // R8
  half_level_chk: assert property (@(posedge clk) disable iff (rst_any)
    1'b1 |=> (half_n_o == !$past(hf_hit)));

  // R9
  afull_level_chk: assert property (@(posedge clk) disable iff (rst_any)
    1'b1 |=> (afull_n_o == !$past(af_hit)));

endmodule

bind fifo_flag_gen ffg_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_all     (rst_all),
  .rst_part    (rst_part),
  .mode_sel_i  (mode_sel_i),
  .mode_q      (mode_q),
  .level_i     (level_i),
  .empty_ofs_i (empty_ofs_i),
  .full_ofs_i  (full_ofs_i),
  .fi_o        (fi_o),
  .eo_o        (eo_o),
  .half_n_o    (half_n_o),
  .aempty_n_o  (aempty_n_o),
  .afull_n_o   (afull_n_o)
);

// File: tb/fifo_flag_gen_test.sv
`timescale 1ns/1ps
module fifo_flag_gen_test;

  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 2);
  localparam int OFS_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_all, rst_part, mode_sel;
  logic [CNT_W-1:0] level;
  logic [OFS_W-1:0] eofs, fofs;
  logic fi, eo, half_n, aempty_n, afull_n;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  bit    mode_exp = 0;
  int    hc[3], hn[3], hm[3];
  int    valid = 0;
  string rtag = "R1";
  string tag_x = "";

  always #2 clk = ~clk;

  fifo_flag_gen #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_all(rst_all), .rst_part(rst_part), .mode_sel_i(mode_sel),
    .level_i(level), .empty_ofs_i(eofs), .full_ofs_i(fofs),
    .fi_o(fi), .eo_o(eo), .half_n_o(half_n), .aempty_n_o(aempty_n), .afull_n_o(afull_n)
  );

  // {fi, eo, half_n, aempty_n, afull_n}
  function automatic logic [4:0] ref_flags(bit fall, int c, int n, int m);
    int   k;
    logic rfi, reo;
    k   = fall ? 1 : 0;
    rfi = fall ? (c == DEPTH + 1) : (c != DEPTH);
    reo = fall ? (c == 0) : (c != 0);
    return {rfi, reo, !(c > DEPTH / 2 + k), !(c <= n + k), !(c >= DEPTH - m + k)};
  endfunction

  function automatic logic [4:0] ref_idle(bit fall);
    return {~fall, fall, 1'b1, 1'b0, 1'b1};
  endfunction

  task automatic chk(string name, string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s%s: actual=%0b expected=%0b", tag, name, tag_x, act, exp);
    end
  endtask

  task automatic check_all();
    logic [4:0] r0, r1, r2, rr;
    rr = ref_idle(mode_exp);
    r0 = (valid >= 1) ? ref_flags(mode_exp, hc[0], hn[0], hm[0]) : rr;
    r1 = (valid >= 2) ? ref_flags(mode_exp, hc[1], hn[1], hm[1]) : rr;
    r2 = (valid >= 3) ? ref_flags(mode_exp, hc[2], hn[2], hm[2]) : rr;
    chk("half_n",   (valid >= 1) ? "R8" : rtag, half_n,   r0[2]);
    chk("aempty_n", (valid >= 1) ? "R7" : rtag, aempty_n, r0[1]);
    chk("afull_n",  (valid >= 1) ? "R9" : rtag, afull_n,  r0[0]);
    chk("fi", (valid >= 2) ? (mode_exp ? "R6" : "R4") : rtag, fi, r1[4]);
    if (mode_exp) chk("eo", (valid >= 3) ? "R5" : rtag, eo, r2[3]);
    else          chk("eo", (valid >= 2) ? "R3" : rtag, eo, r1[3]);
  endtask

  task automatic step(int c, int n, int m, bit ra, bit rp, bit ms);
    @(negedge clk);
    check_all();
    level    = CNT_W'(c);
    eofs     = OFS_W'(n);
    fofs     = OFS_W'(m);
    rst_all  = ra;
    rst_part = rp;
    mode_sel = ms;
    @(posedge clk);
    if (ra) begin
      mode_exp = ms; valid = 0; rtag = "R1";
    end else if (rp) begin
      valid = 0; rtag = "R2";
    end else begin
      for (int i = 2; i > 0; i--) begin
        hc[i] = hc[i-1]; hn[i] = hn[i-1]; hm[i] = hm[i-1];
      end
      hc[0] = c; hn[0] = n; hm[0] = m;
      valid++;
    end
  endtask

  task automatic sweep(bit fall, int n, int m);
    int top;
    top = fall ? DEPTH + 1 : DEPTH;
    for (int c = 0; c <= top; c++) step(c, n, m, 0, 0, 0);
    for (int c = top; c >= 0; c--) step(c, n, m, 0, 0, 0);
  endtask

  task automatic rand_run(bit fall, int cycles);
    int top;
    top = fall ? DEPTH + 1 : DEPTH;
    tag_x = " (R10 random offsets)";
    for (int i = 0; i < cycles; i++)
      step($urandom_range(top, 0), $urandom_range(DEPTH - 1, 0),
           $urandom_range(DEPTH - 1, 0), 0, 0, 0);
    tag_x = "";
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_all = 1; rst_part = 0; mode_sel = 0;
    level = '0; eofs = '0; fofs = '0;
    repeat (2) @(posedge clk);
    mode_exp = 0; valid = 0;

    // R1: standard mode idle values, held through reset
    step(0, 7, 7, 1, 0, 0);
    step(0, 7, 7, 1, 0, 0);
    // R3 R4 R7 R8 R9: full sweep in standard mode, then boundaries with other offsets
    sweep(0, 7, 7);
    sweep(0, 0, 1);
    sweep(0, DEPTH - 1, DEPTH - 1);
    // R3: single-cycle pulses across the empty boundary
    step(1, 3, 3, 0, 0, 0); step(0, 3, 3, 0, 0, 0); step(1, 3, 3, 0, 0, 0);
    step(0, 3, 3, 0, 0, 0); step(0, 3, 3, 0, 0, 0); step(0, 3, 3, 0, 0, 0);
    rand_run(0, 600);

    // R2: partial reset with opposite select keeps standard mode
    step(DEPTH, 5, 5, 0, 1, 1);
    step(DEPTH, 5, 5, 0, 1, 1);
    for (int i = 0; i < 4; i++) step(DEPTH, 5, 5, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 5, 5, 0, 0, 0);

    // R1: full reset into fall-through mode
    step(0, 9, 9, 1, 0, 1);
    step(0, 9, 9, 1, 0, 1);
    // R5 R6 R7 R8 R9: sweeps in fall-through mode
    sweep(1, 9, 9);
    sweep(1, 0, 1);
    sweep(1, DEPTH - 1, DEPTH - 1);
    // R5: three-stage latency around zero
    step(1, 3, 3, 0, 0, 0); step(0, 3, 3, 0, 0, 0); step(2, 3, 3, 0, 0, 0);
    step(0, 3, 3, 0, 0, 0); step(0, 3, 3, 0, 0, 0); step(0, 3, 3, 0, 0, 0);
    rand_run(1, 600);

    // R2: partial reset with select low keeps fall-through mode
    step(0, 5, 5, 0, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 5, 5, 0, 0, 0);
    step(DEPTH + 1, 5, 5, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(DEPTH + 1, 5, 5, 0, 0, 0);

    // R10: offset changes alone with the level held fixed
    for (int i = 0; i < 40; i++) step(20, i % DEPTH, (i * 3) % DEPTH, 0, 0, 0);

    step(0, 5, 5, 0, 0, 0);
    finish_run();
  end

endmodule